// File: doc/BRIEF.md
# Debug Command Decoder with Idle-Cycle RAM Access

This block sits behind an external debug link. The link's receiver presents each 32-bit command word in parallel with a one-cycle valid strobe. The block decodes a three-bit command code from bits 18:16 of the word and acts on it. It can fetch a word from the on-chip RAM, force a new value into the RAM and read it back as a check, repeat the last reported value, or raise an interrupt request. A two-word recovery sequence resets the command engine after a runaway condition.

RAM accesses go through a single-port request interface. A request is issued only in a cycle where the CPU is not using the RAM, so the CPU never waits. Results go to the transmit path as a 32-bit word with a one-cycle valid strobe. While a RAM access is still in progress, any new read, write or monitor command is dropped. Interrupt and recovery commands are still acted on during that time.

Top module: `dbg_cmd_snoop`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `ram_req`, `tx_valid`, `irq_pulse` and `recover_pulse` are low.
- R2: Code 010 in bits 18:16 is a read. Bits 15:2 give the word index and bits 1:0 are ignored. `tx_valid` rises for one cycle after the third rising edge, counting from the edge that sampled the word (first edge), when the CPU is idle. `tx_data` then carries the RAM word.
- R3: Outside recovery handling, bit 19 and bits 31:20 do not affect how a word is decoded.
- R4: `ram_req` is never high while `cpu_busy` is high. A pending access waits and is issued on the first edge at which `cpu_busy` is low.
- R5: Code 011 is a write to the word at bits 15:2. The next received word, even an all-ones word, is the data. That data is written, the same word is read back, and the read-back value appears on `tx_data` after the fourth edge from the data word.
- R6: Code 000 sends the most recent read or verify result again, with `tx_valid` high after the second edge.
- R7: Codes 100, 101 and 110 produce a one-cycle `irq_pulse` after the first edge, with no RAM access and no transmit.
- R8: Code 001, and code 111 in a word that is not all ones, are discarded. They cause no RAM request, no transmit and no pulse.
- R9: A single all-ones word that is not followed directly by a second one has no effect. The word after it is decoded normally.
- R10: Two all-ones words in a row produce a one-cycle `recover_pulse` after the first edge that samples the second word.
- R11: After a recovery pair, the next word is discarded unless bits 31:20 are all ones. Only that one word is checked this way.
- R12: A recovery pair cancels a RAM access that is still pending. After it, no request and no transmit result from that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received command word is valid this cycle |
| rx_word | input | 32 | Received command or data word |
| cpu_busy | input | 1 | CPU is using the RAM this cycle |
| ram_req | output | 1 | RAM access request |
| ram_we | output | 1 | Request is a write |
| ram_addr | output | 14 | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, valid the cycle after a read request |
| tx_valid | output | 1 | Result word is valid this cycle |
| tx_data | output | 32 | Result word to the transmit path |
| irq_pulse | output | 1 | One-cycle interrupt request |
| recover_pulse | output | 1 | One-cycle recovery indication |

## Verification
Every result has a fixed delay, counted in rising edges from the edge that samples the word. An interrupt or recovery pulse appears after one edge and a monitor result after two. A read result appears after three edges plus one for each cycle the CPU holds the RAM, and a write's verify result appears four edges after the data word. The bench drives words at falling edges and counts falling edges until `tx_valid` is seen. It then compares that count with the expected delay, so an early or late result fails just as wrong data does. For discarded words, the bench watches every output for several cycles and checks that all of them stay low.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 14;
    localparam int CODE_LSB = 16;
    localparam int HI_LSB   = 20;

    typedef enum logic [1:0] {
        OP_READ,
        OP_WRITE,
        OP_MON
    } op_kind_e;

    typedef struct packed {
        op_kind_e            kind;
        logic [ADDR_W-1:0]   addr;
        logic [WORD_W-1:0]   data;
    } ram_op_t;

    typedef enum logic [2:0] {
        CMD_MON,
        CMD_RSVD,
        CMD_READ,
        CMD_WRITE,
        CMD_IRQ,
        CMD_DROP
    } cmd_e;

    function automatic cmd_e classify(input logic [2:0] code);
        case (code)
            3'b000:  return CMD_MON;
            3'b001:  return CMD_RSVD;
            3'b010:  return CMD_READ;
            3'b011:  return CMD_WRITE;
            3'b111:  return CMD_DROP;
            default: return CMD_IRQ;
        endcase
    endfunction
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
    import dbg_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    output logic              op_valid,
    output ram_op_t           op,
    output logic              irq_pulse,
    output logic              recover_pulse
);
    logic              armed_q;
    logic              post_q;
    logic              wr_wait_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic              all_ones;
    logic              hi_ok;
    logic [ADDR_W-1:0] addr_f;

    assign all_ones = &rx_word;
    assign hi_ok    = &rx_word[WORD_W-1:HI_LSB];
    assign addr_f   = rx_word[ADDR_W+1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q       <= 1'b0;
            post_q        <= 1'b0;
            wr_wait_q     <= 1'b0;
            wr_addr_q     <= '0;
            op_valid      <= 1'b0;
            op            <= '0;
            irq_pulse     <= 1'b0;
            recover_pulse <= 1'b0;
        end else begin
            op_valid      <= 1'b0;
            irq_pulse     <= 1'b0;
            recover_pulse <= 1'b0;
            if (rx_valid) begin
                if (wr_wait_q) begin
                    wr_wait_q <= 1'b0;
                    armed_q   <= 1'b0;
                    op_valid  <= 1'b1;
                    op        <= '{kind: OP_WRITE, addr: wr_addr_q, data: rx_word};
                end else if (all_ones) begin
                    post_q <= 1'b0;
                    if (armed_q) begin
                        armed_q       <= 1'b0;
                        post_q        <= 1'b1;
                        recover_pulse <= 1'b1;
                    end else begin
                        armed_q <= 1'b1;
                    end
                end else begin
                    armed_q <= 1'b0;
                    post_q  <= 1'b0;
                    if (!post_q || hi_ok) begin
                        case (classify(rx_word[CODE_LSB+2:CODE_LSB]))
                            CMD_READ: begin
                                op_valid <= 1'b1;
                                op       <= '{kind: OP_READ, addr: addr_f, data: '0};
                            end
                            CMD_WRITE: begin
                                wr_wait_q <= 1'b1;
                                wr_addr_q <= addr_f;
                            end
                            CMD_MON: begin
                                op_valid <= 1'b1;
                                op       <= '{kind: OP_MON, addr: '0, data: '0};
                            end
                            CMD_IRQ:  irq_pulse <= 1'b1;
                            default:  ;
                        endcase
                    end
                end
            end
        end
    end

    // R7: an interrupt pulse only follows a received non-all-ones word
    p_irq_from_word_r7: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(rx_valid && !(&rx_word)));

    // R10: recovery pulse only follows a sampled all-ones word
    p_recover_pair_r10: assert property (@(posedge clk) disable iff (rst)
        recover_pulse |-> $past(rx_valid && (&rx_word)));

    // R8: reserved code yields neither an operation nor an interrupt
    p_reserved_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !wr_wait_q && rx_word[CODE_LSB+2:CODE_LSB] == 3'b001)
        |=> (!op_valid && !irq_pulse));
endmodule

// File: rtl/dbg_ram_seq.sv
module dbg_ram_seq
    import dbg_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              op_valid,
    input  ram_op_t           op,
    input  logic              cpu_busy,
    input  logic [WORD_W-1:0] ram_rdata,
    output logic              ram_req,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data
);
    typedef enum logic [2:0] {
        S_IDLE, S_RD_PEND, S_WR_PEND, S_VF_PEND, S_RD_DATA, S_MON
    } seq_state_e;

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] last_q;
    logic              pend;

    assign pend      = (state_q == S_RD_PEND) || (state_q == S_WR_PEND) ||
                       (state_q == S_VF_PEND);
    assign ram_req   = pend && !cpu_busy;
    assign ram_we    = ram_req && (state_q == S_WR_PEND);
    assign ram_addr  = addr_q;
    assign ram_wdata = data_q;
    assign tx_valid  = (state_q == S_RD_DATA) || (state_q == S_MON);
    assign tx_data   = (state_q == S_MON) ? last_q : ram_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
        end else if (state_q == S_RD_DATA) begin
            last_q <= ram_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (op_valid) begin
                    addr_q <= op.addr;
                    data_q <= op.data;
                    case (op.kind)
                        OP_READ:  state_q <= S_RD_PEND;
                        OP_WRITE: state_q <= S_WR_PEND;
                        default:  state_q <= S_MON;
                    endcase
                end
                S_RD_PEND, S_VF_PEND: if (!cpu_busy) state_q <= S_RD_DATA;
                S_WR_PEND:            if (!cpu_busy) state_q <= S_VF_PEND;
                default:              state_q <= S_IDLE;
            endcase
        end
    end

    // R4: a pending access waits unchanged while the CPU holds the RAM
    p_busy_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (pend && cpu_busy && !flush) |=> (state_q == $past(state_q)));

    // R5: a granted write is followed by a verify read of the same word
    p_write_then_verify_r5: assert property (@(posedge clk) disable iff (rst)
        (ram_req && ram_we && !flush) |=> (state_q == S_VF_PEND && $stable(ram_addr)));

    // R2: a RAM-sourced result follows a granted read request
    p_tx_after_read_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RD_DATA) |-> $past(ram_req && !ram_we));
endmodule

// File: rtl/dbg_cmd_snoop.sv
module dbg_cmd_snoop
    import dbg_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              cpu_busy,
    output logic              ram_req,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    input  logic [WORD_W-1:0] ram_rdata,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    output logic              irq_pulse,
    output logic              recover_pulse
);
    logic    op_valid;
    ram_op_t op;

    dbg_cmd_decode u_decode (
        .clk           (clk),
        .rst           (rst),
        .rx_valid      (rx_valid),
        .rx_word       (rx_word),
        .op_valid      (op_valid),
        .op            (op),
        .irq_pulse     (irq_pulse),
        .recover_pulse (recover_pulse)
    );

    dbg_ram_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .flush     (recover_pulse),
        .op_valid  (op_valid),
        .op        (op),
        .cpu_busy  (cpu_busy),
        .ram_rdata (ram_rdata),
        .ram_req   (ram_req),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    // R4: no RAM request reaches the port while the CPU owns the RAM
    p_no_req_when_busy_r4: assert property (@(posedge clk) disable iff (rst)
        cpu_busy |-> !ram_req);
endmodule

// File: tb/dbg_cmd_snoop_tb.sv
module dbg_cmd_snoop_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_word = '0;
    logic        cpu_busy = 1'b0;
    logic        ram_req, ram_we, tx_valid, irq_pulse, recover_pulse;
    logic [13:0] ram_addr;
    logic [31:0] ram_wdata, tx_data;
    logic [31:0] ram_rdata = '0;
    logic [31:0] mem [256];

    int checks = 0;
    int fails  = 0;
    int busy_viol = 0;

    always #10 clk = ~clk;

    dbg_cmd_snoop u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_word(rx_word),
        .cpu_busy(cpu_busy), .ram_req(ram_req), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq_pulse(irq_pulse),
        .recover_pulse(recover_pulse)
    );

    always @(posedge clk) begin
        if (ram_req) begin
            if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
            else        ram_rdata <= mem[ram_addr[7:0]];
        end
    end

    always @(negedge clk) if (ram_req && cpu_busy) busy_viol++;

    function automatic logic [31:0] pat(input int i);
        return {8'hC3, i[7:0], 16'(i * 7 + 3)};
    endfunction

    localparam logic [31:0] RD_TAB [6] = '{
        32'h0002_0000, 32'h0002_0013, 32'h000A_0020,
        32'hFFF2_03FC, 32'h0002_0101, 32'h000A_0086
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_word  = w;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_word  = '0;
    endtask

    task automatic wait_tx(input int start, output int cyc, output logic [31:0] d);
        cyc = start;
        while (!tx_valid && cyc < 30) begin
            @(negedge clk);
            cyc++;
        end
        d = tx_data;
    endtask

    task automatic quiet(input int n, input string tag);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            if (tx_valid || ram_req || irq_pulse || recover_pulse) hits++;
            @(negedge clk);
        end
        check(hits == 0, tag, hits, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        logic [31:0] d;
        logic [31:0] last;
        for (int i = 0; i < 256; i++) mem[i] = pat(i);

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!ram_req && !tx_valid && !irq_pulse && !recover_pulse, "R1 during reset",
              {ram_req, tx_valid, irq_pulse, recover_pulse}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!ram_req && !tx_valid && !irq_pulse && !recover_pulse, "R1 after reset",
              {ram_req, tx_valid, irq_pulse, recover_pulse}, 0);

        // R2/R3: table of read commands, low address bits and high bits ignored
        foreach (RD_TAB[k]) begin
            send(RD_TAB[k]);
            wait_tx(1, cyc, d);
            check(d == pat(int'(RD_TAB[k][9:2])), "R2 R3 read data", d, pat(int'(RD_TAB[k][9:2])));
            check(cyc == 3, "R2 read latency", cyc, 3);
            last = d;
            @(negedge clk);
            check(!tx_valid, "R2 single-cycle tx", tx_valid, 0);
        end

        // R6: monitor resends last result
        send(32'h0000_0000);
        wait_tx(1, cyc, d);
        check(d == last && cyc == 2, "R6 monitor", d, last);
        @(negedge clk);
        send(32'h0008_0000);
        wait_tx(1, cyc, d);
        check(d == last && cyc == 2, "R6 R3 monitor bit19", d, last);
        @(negedge clk);

        // R4: CPU busy delays the read
        cpu_busy = 1'b1;
        send(32'h0002_0040);
        cyc = 1;
        for (int i = 0; i < 4; i++) begin
            check(!tx_valid, "R4 no tx while busy", tx_valid, 0);
            @(negedge clk);
            cyc++;
        end
        cpu_busy = 1'b0;
        wait_tx(cyc, cyc, d);
        check(d == pat(16) && cyc == 6, "R4 delayed read", cyc, 6);
        @(negedge clk);

        // R5: write with verify
        send(32'h0003_0050);
        send(32'hDEAD_BEEF);
        wait_tx(1, cyc, d);
        check(d == 32'hDEAD_BEEF, "R5 verify data", d, 32'hDEAD_BEEF);
        check(cyc == 4, "R5 verify latency", cyc, 4);
        check(mem[20] == 32'hDEAD_BEEF, "R5 ram updated", mem[20], 32'hDEAD_BEEF);
        @(negedge clk);
        send(32'h0003_0054);
        send(32'hFFFF_FFFF);
        wait_tx(1, cyc, d);
        check(d == 32'hFFFF_FFFF && !recover_pulse, "R5 all-ones as data", d, 32'hFFFF_FFFF);
        @(negedge clk);

        // R7: interrupt codes
        foreach (RD_TAB[k]) if (k < 4) begin
            logic [31:0] w;
            w = (k == 3) ? 32'h000C_0000 : (32'h0004_0000 + (32'(k) << 16));
            send(w);
            check(irq_pulse && !tx_valid, "R7 irq pulse", irq_pulse, 1);
            @(negedge clk);
            check(!irq_pulse, "R7 irq one cycle", irq_pulse, 0);
            quiet(3, "R7 no ram or tx");
        end

        // R8: reserved and code 111 dropped
        send(32'h0001_0000);
        quiet(6, "R8 reserved ignored");
        send(32'h0007_0010);
        quiet(6, "R8 code 111 ignored");

        // R9: lone all-ones then a normal read
        send(32'hFFFF_FFFF);
        check(!recover_pulse, "R9 lone all-ones", recover_pulse, 0);
        send(32'h0002_0008);
        wait_tx(1, cyc, d);
        check(d == pat(2) && cyc == 3, "R9 following read", d, pat(2));
        @(negedge clk);

        // R10: recovery pair
        send(32'hFFFF_FFFF);
        send(32'hFFFF_FFFF);
        check(recover_pulse, "R10 recover pulse", recover_pulse, 1);
        @(negedge clk);
        check(!recover_pulse, "R10 one cycle", recover_pulse, 0);

        // R11: word after recovery needs ones in 31:20
        send(32'h0002_0004);
        quiet(6, "R11 discarded after recovery");
        send(32'h0002_000C);
        wait_tx(1, cyc, d);
        check(d == pat(3) && cyc == 3, "R11 check only once", d, pat(3));
        @(negedge clk);
        send(32'hFFFF_FFFF);
        send(32'hFFFF_FFFF);
        send(32'hFFF2_0004);
        wait_tx(1, cyc, d);
        check(d == pat(1) && cyc == 3, "R11 accepted with ones", d, pat(1));
        @(negedge clk);

        // R12: recovery cancels a pending read
        cpu_busy = 1'b1;
        send(32'h0002_0010);
        @(negedge clk);
        send(32'hFFFF_FFFF);
        send(32'hFFFF_FFFF);
        @(negedge clk);
        cpu_busy = 1'b0;
        quiet(6, "R12 pending access cancelled");

        check(busy_viol == 0, "R4 no request while busy", busy_viol, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule